// File: doc/BRIEF.md
# Way-Predicting Set-Associative Tag Lookup

This block is the lookup front end of a set-associative cache. Every set holds a small prediction field that names the way the next access to that set is expected to hit. When a request arrives, the block reads the prediction, steers the data multiplexer to that way and compares only that way's tag. A correct guess returns hit data one cycle after the request is accepted.

When the guess is wrong, the block holds off new requests for one cycle. In that cycle it compares the stored tag against every other way of the set. A hit there is returned with a flag marking it as slow, and the set's prediction is rewritten to the way that hit. If nothing matches, a miss is returned at the same two-cycle latency. Tags, valid bits, data and predictions live in internal register arrays. A separate port writes a line into a chosen way, which also points the prediction at that way, or invalidates one way. Choosing a victim and fetching lines from memory are left to the surrounding cache.

Top module: `waypred_tag_lookup`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, every way of every set is invalid (any lookup misses, including tag 0), and every set predicts way 0.
- R2: A request accepted (req_valid_i and req_ready_o both 1 at a clock edge) whose predicted way is valid with an equal tag gives, in the next cycle, rsp_valid_o=1, rsp_hit_o=1, rsp_slow_o=0, rsp_way_o equal to the predicted way and rsp_data_o equal to that way's data.
- R3: If the predicted way does not match, req_ready_o is 0 and rsp_valid_o is 0 in the cycle after acceptance. In the cycle after that the response has rsp_hit_o=1, rsp_slow_o=1, and the lowest-numbered matching valid way other than the predicted one, together with its data.
- R4: After a slow hit, the prediction of that set equals the way that hit, so an immediate repeat of the same lookup is a fast hit.
- R5: If no valid way matches, the response comes two cycles after acceptance with rsp_hit_o=0, rsp_slow_o=1, rsp_way_o=0 and rsp_data_o=0.
- R6: A fill (fill_valid_i=1, fill_inval_i=0) writes tag, data and a set valid bit into way fill_way_i of set fill_index_i, and sets that set's prediction to fill_way_i.
- R7: An invalidate (fill_valid_i=1, fill_inval_i=1) clears the valid bit of the chosen way and leaves the prediction unchanged. A later lookup of the old tag misses, and a match in another way is found in the second cycle.
- R8: A request presented while req_ready_o is 0 is not accepted and produces no response. req_ready_o is low for exactly one cycle per mispredicted access.
- R9: Predictions are kept per set: retraining one set does not change the prediction of any other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| req_index_i | input | IDX_W | Set index of the lookup |
| req_tag_i | input | TAG_W | Physical tag of the lookup |
| fill_valid_i | input | 1 | Fill or invalidate strobe |
| fill_inval_i | input | 1 | 1 = invalidate the way, 0 = write the line |
| fill_index_i | input | IDX_W | Set written by the fill port |
| fill_way_i | input | WAY_W | Way written by the fill port |
| fill_tag_i | input | TAG_W | Tag written on a fill |
| fill_data_i | input | DATA_W | Data written on a fill |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_slow_o | output | 1 | 1 = resolved in the second cycle (mispredicted hit or miss) |
| rsp_way_o | output | WAY_W | Way that hit |
| rsp_data_o | output | DATA_W | Data of the way that hit |

## Verification
A stale or corrupted prediction never changes which line is returned. It shows only as a wrong rsp_slow_o flag and a one-cycle ready bubble, on the very next access to that set. A bad tag or valid bit shows as a wrong hit, way or data on the first lookup that touches it. The bench therefore checks the full response together with its latency on every access, and repeats each slow lookup to confirm that retraining took hold.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_RECHECK = 1'b1
  } wp_state_e;
endpackage

// File: rtl/wp_store.sv
module wp_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            wr_inval_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [WAY_W-1:0]                wr_way_i,
  input  logic [TAG_W-1:0]                wr_tag_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic [IDX_W-1:0]                rd_idx_i,
  output logic [WAYS-1:0]                 rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag_o,
  output logic [WAYS-1:0][DATA_W-1:0]     rd_data_o
);
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        data_q[s]  <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_inval_i) begin
        valid_q[wr_idx_i][wr_way_i] <= 1'b0;
      end else begin
        valid_q[wr_idx_i][wr_way_i] <= 1'b1;
        tag_q[wr_idx_i][wr_way_i]   <= wr_tag_i;
        data_q[wr_idx_i][wr_way_i]  <= wr_data_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  // R7: an invalidate leaves the way unusable at the next edge
  p_inval_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_inval_i) |=> !valid_q[$past(wr_idx_i)][$past(wr_way_i)]);
endmodule

// File: rtl/wp_predictor.sv
module wp_predictor #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             train_en_i,
  input  logic [IDX_W-1:0] train_idx_i,
  input  logic [WAY_W-1:0] train_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] pred_way_o
);
  logic [WAY_W-1:0] pred_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) pred_q[s] <= '0;
    end else begin
      if (train_en_i) pred_q[train_idx_i] <= train_way_i;
      if (fill_en_i)  pred_q[fill_idx_i]  <= fill_way_i;  // fill wins on a clash
    end
  end

  assign pred_way_o = pred_q[rd_idx_i];

  p_train_sticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_en_i && !(fill_en_i && fill_idx_i == train_idx_i))
      |=> pred_q[$past(train_idx_i)] == $past(train_way_i));

  p_fill_points_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> pred_q[$past(fill_idx_i)] == $past(fill_way_i));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [IDX_W-1:0]            req_index_i,
  input  logic [TAG_W-1:0]            req_tag_i,
  input  logic [WAY_W-1:0]            pred_way_i,
  output logic [IDX_W-1:0]            rd_idx_o,
  input  logic [WAYS-1:0]             rd_valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag_i,
  input  logic [WAYS-1:0][DATA_W-1:0] rd_data_i,
  output logic                        train_en_o,
  output logic [IDX_W-1:0]            train_idx_o,
  output logic [WAY_W-1:0]            train_way_o,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic                        rsp_slow_o,
  output logic [WAY_W-1:0]            rsp_way_o,
  output logic [DATA_W-1:0]           rsp_data_o
);
  wp_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [WAY_W-1:0] pw_q;

  logic              accept;
  logic [DATA_W-1:0] pre_data;
  logic              fast_hit;
  logic [WAYS-1:0]   other_match;
  logic              slow_hit;
  logic [WAY_W-1:0]  slow_way;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rd_idx_o    = req_ready_o ? req_index_i : idx_q;

  // mux preset from the prediction, single tag compare
  assign pre_data = rd_data_i[pred_way_i];
  assign fast_hit = rd_valid_i[pred_way_i] && (rd_tag_i[pred_way_i] == req_tag_i);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign other_match[w] = (pw_q != WAY_W'(w)) && rd_valid_i[w] && (rd_tag_i[w] == tag_q);
  end

  always_comb begin
    slow_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (other_match[w]) slow_way = WAY_W'(w);
    end
  end
  assign slow_hit = |other_match;

  assign train_en_o  = (state_q == ST_RECHECK) && slow_hit;
  assign train_idx_o = idx_q;
  assign train_way_o = slow_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      tag_q       <= '0;
      pw_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_slow_o  <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_slow_o  <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
      if (state_q == ST_RECHECK) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_slow_o  <= 1'b1;
        rsp_hit_o   <= slow_hit;
        if (slow_hit) begin
          rsp_way_o  <= slow_way;
          rsp_data_o <= rd_data_i[slow_way];
        end
      end else if (accept) begin
        if (fast_hit) begin
          rsp_valid_o <= 1'b1;
          rsp_hit_o   <= 1'b1;
          rsp_way_o   <= pred_way_i;
          rsp_data_o  <= pre_data;
        end else begin
          state_q <= ST_RECHECK;
          idx_q   <= req_index_i;
          tag_q   <= req_tag_i;
          pw_q    <= pred_way_i;
        end
      end
    end
  end

  p_accept_progress_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_valid_o != !req_ready_o));

  p_fast_is_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_slow_o) |-> rsp_hit_o);

  p_bubble_then_slow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (rsp_valid_o && rsp_slow_o));

  p_miss_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_slow_o && rsp_way_o == '0 && rsp_data_o == '0));

  p_one_bubble_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);
endmodule

// File: rtl/waypred_tag_lookup.sv
module waypred_tag_lookup #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IDX_W-1:0]  req_index_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              fill_valid_i,
  input  logic              fill_inval_i,
  input  logic [IDX_W-1:0]  fill_index_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_slow_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [IDX_W-1:0]             rd_idx;
  logic [WAYS-1:0]              rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
  logic [WAYS-1:0][DATA_W-1:0]  rd_data;
  logic [WAY_W-1:0]             pred_way;
  logic                         train_en;
  logic [IDX_W-1:0]             train_idx;
  logic [WAY_W-1:0]             train_way;

  wp_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (fill_valid_i),
    .wr_inval_i(fill_inval_i),
    .wr_idx_i  (fill_index_i),
    .wr_way_i  (fill_way_i),
    .wr_tag_i  (fill_tag_i),
    .wr_data_i (fill_data_i),
    .rd_idx_i  (rd_idx),
    .rd_valid_o(rd_valid),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data)
  );

  wp_predictor #(.SETS(SETS), .WAYS(WAYS)) u_pred (
    .clk_i, .rst_ni,
    .fill_en_i  (fill_valid_i && !fill_inval_i),
    .fill_idx_i (fill_index_i),
    .fill_way_i (fill_way_i),
    .train_en_i (train_en),
    .train_idx_i(train_idx),
    .train_way_i(train_way),
    .rd_idx_i   (req_index_i),
    .pred_way_o (pred_way)
  );

  wp_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_index_i, .req_tag_i,
    .pred_way_i (pred_way),
    .rd_idx_o   (rd_idx),
    .rd_valid_i (rd_valid),
    .rd_tag_i   (rd_tag),
    .rd_data_i  (rd_data),
    .train_en_o (train_en),
    .train_idx_o(train_idx),
    .train_way_o(train_way),
    .rsp_valid_o, .rsp_hit_o, .rsp_slow_o, .rsp_way_o, .rsp_data_o
  );
endmodule

// File: tb/waypred_tag_lookup_test.sv
module waypred_tag_lookup_test;
  localparam int PERIOD = 10;
  localparam int SETS = 4, WAYS = 4, TAG_W = 10, DATA_W = 32;
  localparam int IDX_W = $clog2(SETS), WAY_W = $clog2(WAYS);
  localparam int RW = 3 + WAY_W + DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [IDX_W-1:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic fill_valid = 1'b0, fill_inval = 1'b0;
  logic [IDX_W-1:0] fill_index = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic rsp_valid, rsp_hit, rsp_slow;
  logic [WAY_W-1:0] rsp_way;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0, errors = 0;

  bit              m_val  [SETS][WAYS];
  logic [TAG_W-1:0]  m_tag  [SETS][WAYS];
  logic [DATA_W-1:0] m_data [SETS][WAYS];
  int              m_pred [SETS];

  always #(PERIOD/2) clk = ~clk;

  waypred_tag_lookup #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_index_i(req_index), .req_tag_i(req_tag),
    .fill_valid_i(fill_valid), .fill_inval_i(fill_inval),
    .fill_index_i(fill_index), .fill_way_i(fill_way),
    .fill_tag_i(fill_tag), .fill_data_i(fill_data),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_slow_o(rsp_slow),
    .rsp_way_o(rsp_way), .rsp_data_o(rsp_data)
  );

  function automatic logic [TAG_W-1:0] tag_of(int s, int w);
    return TAG_W'(10'h100 | (s << 4) | w);
  endfunction

  function automatic logic [DATA_W-1:0] data_of(int s, int w, int gen);
    return DATA_W'(32'hA000_0000 | (gen << 16) | (s << 8) | w);
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(int s, int w, bit inval, logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    fill_valid = 1'b1; fill_inval = inval;
    fill_index = IDX_W'(s); fill_way = WAY_W'(w);
    fill_tag = t; fill_data = d;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0; fill_inval = 1'b0;
    if (inval) m_val[s][w] = 1'b0;
    else begin
      m_val[s][w] = 1'b1; m_tag[s][w] = t; m_data[s][w] = d; m_pred[s] = w;
    end
  endtask

  // Called at a negedge; checks response content and latency
  task automatic access(int s, logic [TAG_W-1:0] t, string rq);
    int pw = m_pred[s];
    bit fast = m_val[s][pw] && (m_tag[s][pw] == t);
    int hw = -1;
    logic [RW-1:0] exp_v, act_v;
    int js = (s + 1) % SETS;
    for (int w = WAYS - 1; w >= 0; w--)
      if (w != pw && m_val[s][w] && m_tag[s][w] == t) hw = w;
    chk(req_ready == 1'b1, rq, "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_index = IDX_W'(s); req_tag = t;
    @(posedge clk); @(negedge clk);
    if (fast) begin
      exp_v = {1'b1, 1'b1, 1'b0, WAY_W'(pw), m_data[s][pw]};
      act_v = {rsp_valid, rsp_hit, rsp_slow, rsp_way, rsp_data};
      chk(act_v == exp_v, rq, "fast response", 64'(act_v), 64'(exp_v));
      req_valid = 1'b0;
    end else begin
      chk({rsp_valid, req_ready} == 2'b00, rq, "bubble {valid,ready}",
          64'({rsp_valid, req_ready}), 64'd0);
      // R8: a request offered during the bubble must be ignored
      req_index = IDX_W'(js); req_tag = m_tag[js][m_pred[js]];
      @(posedge clk); @(negedge clk);
      if (hw >= 0) exp_v = {1'b1, 1'b1, 1'b1, WAY_W'(hw), m_data[s][hw]};
      else         exp_v = {1'b1, 1'b0, 1'b1, WAY_W'(0), DATA_W'(0)};
      act_v = {rsp_valid, rsp_hit, rsp_slow, rsp_way, rsp_data};
      chk(act_v == exp_v, rq, "slow response", 64'(act_v), 64'(exp_v));
      chk(req_ready == 1'b1, "R8", "ready after bubble", 64'(req_ready), 64'd1);
      req_valid = 1'b0;
      if (hw >= 0) m_pred[s] = hw;
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == 1'b0, "R8", "no response for bubble request", 64'(rsp_valid), 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 1'b0; m_tag[s][w] = '0; m_data[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    chk({req_ready, rsp_valid} == 2'b10, "R1", "reset {ready,valid}",
        64'({req_ready, rsp_valid}), 64'd2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R5: empty cache misses everywhere, including tag 0
    for (int s = 0; s < SETS; s++) begin
      access(s, '0, "R1");
      access(s, '1, "R5");
    end

    // R6: fill every way; last fill leaves prediction on the top way
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        fill(s, w, 1'b0, tag_of(s, w), data_of(s, w, 1));
    for (int s = 0; s < SETS; s++) access(s, tag_of(s, WAYS - 1), "R6");

    // R3 / R4: each other way mispredicts once, then hits fast
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS - 1; w++) begin
        access(s, tag_of(s, w), "R3");
        access(s, tag_of(s, w), "R4");
      end

    // R5: unknown tag in a full set
    for (int s = 0; s < SETS; s++) access(s, '1, "R5");

    // R9: retrain set 0 only; set 1 keeps its own prediction
    access(0, tag_of(0, 0), "R3");
    access(1, tag_of(1, WAYS - 2), "R9");
    access(0, tag_of(0, 0), "R9");

    // R7: invalidate the predicted way; old tag misses, other ways still found
    fill(2, WAYS - 2, 1'b1, '0, '0);
    access(2, tag_of(2, WAYS - 2), "R7");
    access(2, tag_of(2, 1), "R7");
    fill(3, 1, 1'b1, '0, '0);
    access(3, tag_of(3, 1), "R7");

    // R6: overwrite a way with a new line; prediction follows the fill
    fill(3, 0, 1'b0, 10'h2AA, data_of(3, 0, 2));
    access(3, 10'h2AA, "R6");
    access(3, tag_of(3, 0), "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule